// File: doc/BRIEF.md
# Nonvolatile Store/Recall Sequence Controller

This block sits beside a shadowed nonvolatile SRAM. It watches the memory's read accesses for an unlock pattern of six addresses. When the pattern completes, it launches one of two operations. A STORE copies the SRAM into its nonvolatile shadow. A RECALL copies the shadow back into the SRAM. Each step of the pattern is the falling edge of the active-low chip enable. The controller samples that enable with its own clock, together with the address bus and the write enable. The clock also times the length of each operation. Output enable has no influence on the pattern.

While an operation runs, the controller raises `busy` and one of two activity strobes. It also holds the memory's data drivers disabled, and it ignores every bus input until the operation ends. After reset it waits for the supply-good indication and then runs a RECALL by itself. A STORE stops at once when the supply-low indication asserts. A RECALL keeps running through it. The memory arrays, the supply comparators and the cell programming lie outside this block. Only the handshake levels described here represent them.

The design has four states. `ST_PWRWAIT` is entered on reset. `ST_IDLE` watches for the pattern. `ST_STORE` and `ST_RECALL` are the two running operations. The transitions between them are:

- PWRWAIT→RECALL when supply is good (power-up restore).
- IDLE→STORE when the sixth address is the store code and the supply is not low.
- IDLE→RECALL when the sixth address is the recall code.
- STORE→IDLE on timer expiry or on supply low (abort).
- RECALL→IDLE on timer expiry.

Top module: `nvs_ctrl`

## Requirements
- R1: While reset is asserted and afterwards until `supply_good` is first sampled high, `busy` and `out_disable` are 1 and both strobes are 0. The clock edge that samples `supply_good` high starts a RECALL. During that RECALL, `recall_active` stays high for exactly RECALL_CYCLES cycles, and then the block is idle.
- R2: A pattern step is a clock edge at which `ce_n` is sampled 0 after being sampled 1 at the edge before, with `we_n` sampled 1 at that same edge. `addr` is taken at that edge. A low time of any number of cycles counts as one step. `oe_n` has no effect on the pattern.
- R3: The steps SEQ_ADDRS[0..4] in order, followed by STORE_ADDR, start a STORE at the edge of the sixth step. `store_active` is then high for exactly STORE_CYCLES cycles.
- R4: The steps SEQ_ADDRS[0..4] in order, followed by RECALL_ADDR, start a RECALL at the edge of the sixth step. `recall_active` is then high for exactly RECALL_CYCLES cycles.
- R5: A step whose address does not match the expected one sets the progress back. Progress becomes 1 if that address equals SEQ_ADDRS[0], and 0 otherwise. As a result, the pattern must be completed again from the point that rule gives.
- R6: A chip-enable falling edge with `we_n` sampled 0 (a write) clears all progress.
- R7: While `busy` is 1, chip-enable activity has no effect. A complete pattern issued during an operation starts nothing afterwards, and progress is 0 when the block returns to idle.
- R8: `supply_low` sampled 1 during a STORE ends it at that edge. `store_active` and `busy` then fall.
- R9: `supply_low` has no effect on a running RECALL, which still lasts RECALL_CYCLES cycles.
- R10: `store_active` and `recall_active` are never both 1. `out_disable` is 1 whenever `busy` is 1. When idle, `out_disable` equals `ce_n | oe_n`.
- R11: A store pattern that completes while `supply_low` is sampled 1 starts no STORE and clears progress.
- R12: A chip-enable low pulse of a single clock cycle advances the pattern.
- R13: Pattern steps made before the power-up RECALL ends are discarded. A complete store pattern during the supply-good wait starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling and cycle-counting clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | AW | Memory address bus |
| ce_n | input | 1 | Active-low chip enable; its falling edge marks a pattern step |
| we_n | input | 1 | Active-low write enable |
| oe_n | input | 1 | Active-low output enable |
| supply_good | input | 1 | Supply above the power-up restore threshold |
| supply_low | input | 1 | Supply below the store-inhibit threshold |
| busy | output | 1 | Power-up wait or an operation in progress |
| store_active | output | 1 | STORE running |
| recall_active | output | 1 | RECALL running |
| out_disable | output | 1 | Forces the data outputs to high impedance |

## Verification
The hardest case to reach is the mismatch that is also a restart. In this case a wrong address in the middle of the pattern equals the first pattern address. The controller must then resume at progress 1, not 0. The stimulus produces it with a pattern of first, second, first, and then the rest. It expects a STORE only if the third step was counted as a fresh start.

Aborting a STORE needs `supply_low` raised for exactly one cycle in the middle of the operation. The stimulus therefore waits a fixed number of cycles after launch before pulsing it.

A complete pattern during the power-up wait checks that steps are discarded. So does a complete pattern during a running STORE. In both cases the reference model and the per-cycle comparison must see no later operation.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

    typedef enum logic [1:0] {
        ST_PWRWAIT = 2'd0,
        ST_IDLE    = 2'd1,
        ST_STORE   = 2'd2,
        ST_RECALL  = 2'd3
    } nvs_state_t;

    typedef enum logic [1:0] {
        REQ_NONE   = 2'd0,
        REQ_STORE  = 2'd1,
        REQ_RECALL = 2'd2
    } nvs_req_t;

endpackage

// File: rtl/nvs_step_detect.sv
module nvs_step_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic we_n,
    output logic read_step,
    output logic write_step
);
    logic ce_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ce_prev <= 1'b1;
        else        ce_prev <= ce_n;
    end

    always_comb begin
        read_step  = ce_prev && !ce_n && we_n;
        write_step = ce_prev && !ce_n && !we_n;
    end
endmodule

// File: rtl/nvs_unlock.sv
module nvs_unlock
    import nvs_pkg::*;
#(
    parameter int                        AW          = 16,
    parameter int                        PREFIX_LEN  = 5,
    parameter logic [PREFIX_LEN*AW-1:0]  SEQ_ADDRS   = {16'h0F7A, 16'h3D04, 16'h2B91, 16'h06E3, 16'h1A5C},
    parameter logic [AW-1:0]             STORE_ADDR  = 16'h15B8,
    parameter logic [AW-1:0]             RECALL_ADDR = 16'h2C47
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          read_step,
    input  logic          write_step,
    input  logic [AW-1:0] addr,
    output nvs_req_t      req
);
    localparam int STW  = $clog2(PREFIX_LEN + 1);
    localparam int HITW = 1 << STW;

    logic [STW-1:0]  step_q, step_d;
    logic [HITW-1:0] hit;

    genvar i;
    generate
        for (i = 0; i < HITW; i++) begin : g_hit
            if (i < PREFIX_LEN) begin : g_cmp
                assign hit[i] = (addr == SEQ_ADDRS[i*AW +: AW]);
            end else begin : g_pad
                assign hit[i] = 1'b0;
            end
        end
    endgenerate

    always_comb begin
        step_d = step_q;
        req    = REQ_NONE;
        if (clear || write_step) begin
            step_d = '0;
        end else if (read_step) begin
            if (step_q == STW'(PREFIX_LEN)) begin
                if (addr == STORE_ADDR)       req = REQ_STORE;
                else if (addr == RECALL_ADDR) req = REQ_RECALL;
                if (req != REQ_NONE) step_d = '0;
                else                 step_d = hit[0] ? STW'(1) : '0;
            end else if (hit[step_q]) begin
                step_d = step_q + STW'(1);
            end else begin
                step_d = hit[0] ? STW'(1) : '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) step_q <= '0;
        else        step_q <= step_d;
    end
endmodule

// File: rtl/nvs_timer.sv
module nvs_timer #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          run,
    output logic          done
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   cnt <= '0;
        else if (load)                cnt <= load_val;
        else if (run && cnt != '0)    cnt <= cnt - CW'(1);
    end

    assign done = run && (cnt == '0);
endmodule

// File: rtl/nvs_ctrl.sv
module nvs_ctrl
    import nvs_pkg::*;
#(
    parameter int                   AW            = 16,
    parameter int                   PREFIX_LEN    = 5,
    parameter logic [PREFIX_LEN*AW-1:0] SEQ_ADDRS = {16'h0F7A, 16'h3D04, 16'h2B91, 16'h06E3, 16'h1A5C},
    parameter logic [AW-1:0]        STORE_ADDR    = 16'h15B8,
    parameter logic [AW-1:0]        RECALL_ADDR   = 16'h2C47,
    parameter int                   STORE_CYCLES  = 2500000,
    parameter int                   RECALL_CYCLES = 5000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          ce_n,
    input  logic          we_n,
    input  logic          oe_n,
    input  logic          supply_good,
    input  logic          supply_low,
    output logic          busy,
    output logic          store_active,
    output logic          recall_active,
    output logic          out_disable
);
    localparam int MAXC = (STORE_CYCLES > RECALL_CYCLES) ? STORE_CYCLES : RECALL_CYCLES;
    localparam int CW   = (MAXC > 2) ? $clog2(MAXC) : 1;
    localparam logic [CW-1:0] STORE_LOAD  = CW'(STORE_CYCLES - 1);
    localparam logic [CW-1:0] RECALL_LOAD = CW'(RECALL_CYCLES - 1);

    nvs_state_t    state, state_nx;
    nvs_req_t      req;
    logic          read_step, write_step;
    logic          t_load, t_run, t_done;
    logic [CW-1:0] t_val;

    nvs_step_detect u_step (
        .clk        (clk),
        .rst_n      (rst_n),
        .ce_n       (ce_n),
        .we_n       (we_n),
        .read_step  (read_step),
        .write_step (write_step)
    );

    nvs_unlock #(
        .AW          (AW),
        .PREFIX_LEN  (PREFIX_LEN),
        .SEQ_ADDRS   (SEQ_ADDRS),
        .STORE_ADDR  (STORE_ADDR),
        .RECALL_ADDR (RECALL_ADDR)
    ) u_unlock (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (state != ST_IDLE),
        .read_step  (read_step),
        .write_step (write_step),
        .addr       (addr),
        .req        (req)
    );

    nvs_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .run      (t_run),
        .done     (t_done)
    );

    // next state and timer control
    always_comb begin
        state_nx = state;
        t_load   = 1'b0;
        t_val    = RECALL_LOAD;
        t_run    = (state == ST_STORE) || (state == ST_RECALL);
        unique case (state)
            ST_PWRWAIT: begin
                if (supply_good) begin
                    state_nx = ST_RECALL;
                    t_load   = 1'b1;
                end
            end
            ST_IDLE: begin
                if (req == REQ_STORE && !supply_low) begin
                    state_nx = ST_STORE;
                    t_load   = 1'b1;
                    t_val    = STORE_LOAD;
                end else if (req == REQ_RECALL) begin
                    state_nx = ST_RECALL;
                    t_load   = 1'b1;
                end
            end
            ST_STORE: begin
                if (supply_low || t_done) state_nx = ST_IDLE;
            end
            ST_RECALL: begin
                if (t_done) state_nx = ST_IDLE;
            end
            default: state_nx = ST_PWRWAIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_PWRWAIT;
        else        state <= state_nx;
    end

    always_comb begin
        busy          = (state != ST_IDLE);
        store_active  = (state == ST_STORE);
        recall_active = (state == ST_RECALL);
        out_disable   = busy || ce_n || oe_n;
    end
endmodule

// File: rtl/nvs_ctrl_chk.sv
module nvs_ctrl_chk #(
    parameter int STORE_CYCLES  = 2500000,
    parameter int RECALL_CYCLES = 5000
) (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic store_active,
    input logic recall_active,
    input logic out_disable,
    input logic supply_low
);
    int scnt, rcnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scnt <= 0;
            rcnt <= 0;
        end else begin
            scnt <= store_active  ? scnt + 1 : 0;
            rcnt <= recall_active ? rcnt + 1 : 0;
        end
    end

    a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(store_active && recall_active));

    a_r10_outdis_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> out_disable);

    a_r8_store_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (store_active && supply_low) |=> !store_active);

    a_r11_no_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(store_active) |-> !$past(supply_low));

    a_r7_start_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(store_active) |-> !$past(busy));

    a_r3_store_len: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(store_active) && !$past(supply_low)) |-> (scnt == STORE_CYCLES));

    a_r4_recall_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(recall_active) |-> (rcnt == RECALL_CYCLES));
endmodule

bind nvs_ctrl nvs_ctrl_chk #(
    .STORE_CYCLES  (STORE_CYCLES),
    .RECALL_CYCLES (RECALL_CYCLES)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .busy          (busy),
    .store_active  (store_active),
    .recall_active (recall_active),
    .out_disable   (out_disable),
    .supply_low    (supply_low)
);

// File: tb/sim_nvs_ctrl.sv
`timescale 1ns/1ps
module sim_nvs_ctrl;
    localparam int AW = 16;
    localparam int ST = 40;
    localparam int RC = 12;
    localparam logic [AW-1:0] SA = 16'h15B8;
    localparam logic [AW-1:0] RA = 16'h2C47;
    localparam logic [AW-1:0] BAD = 16'h0001;

    logic [AW-1:0] seqa [5] = '{16'h1A5C, 16'h06E3, 16'h2B91, 16'h3D04, 16'h0F7A};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic supply_good = 1'b0, supply_low = 1'b0;
    logic busy, store_active, recall_active, out_disable;

    int n_chk = 0, n_fail = 0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    nvs_ctrl #(
        .AW(AW), .STORE_CYCLES(ST), .RECALL_CYCLES(RC),
        .SEQ_ADDRS({16'h0F7A, 16'h3D04, 16'h2B91, 16'h06E3, 16'h1A5C}),
        .STORE_ADDR(SA), .RECALL_ADDR(RA)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .supply_good(supply_good), .supply_low(supply_low),
        .busy(busy), .store_active(store_active), .recall_active(recall_active),
        .out_disable(out_disable)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference: 0 wait, 1 idle, 2 store, 3 recall
    int m_state = 0, m_step = 0, m_rem = 0, m_req = 0;
    bit m_prev_ce = 1'b1, m_fall;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_step = 0; m_rem = 0; m_prev_ce = 1'b1;
        end else begin
            m_fall = m_prev_ce && !ce_n;
            m_req = 0;
            if (m_state != 1 || (m_fall && !we_n)) m_step = 0;
            else if (m_fall) begin
                if (m_step == 5) begin
                    if (addr == SA) m_req = 1;
                    else if (addr == RA) m_req = 2;
                    m_step = (m_req != 0) ? 0 : ((addr == seqa[0]) ? 1 : 0);
                end else if (addr == seqa[m_step]) m_step++;
                else m_step = (addr == seqa[0]) ? 1 : 0;
            end
            case (m_state)
                0: if (supply_good) begin m_state = 3; m_rem = RC; end
                1: if (m_req == 1 && !supply_low) begin m_state = 2; m_rem = ST; end
                   else if (m_req == 2) begin m_state = 3; m_rem = RC; end
                2: begin m_rem--; if (supply_low || m_rem == 0) m_state = 1; end
                default: begin m_rem--; if (m_rem == 0) m_state = 1; end
            endcase
            m_prev_ce = ce_n;
        end
    end

    // per-cycle comparison and operation length measurement
    int s_run = 0, r_run = 0, last_s = 0, last_r = 0, n_store = 0, n_recall = 0;
    always @(negedge clk) begin
        chk(busy == (m_state != 1), {cur_req, " busy"}, busy, m_state != 1);
        chk(store_active == (m_state == 2), {cur_req, " store_active"}, store_active, m_state == 2);
        chk(recall_active == (m_state == 3), {cur_req, " recall_active"}, recall_active, m_state == 3);
        chk(out_disable == ((m_state != 1) || ce_n || oe_n), {cur_req, " out_disable"},
            out_disable, (m_state != 1) || ce_n || oe_n);
        if (store_active) s_run++;
        else if (s_run > 0) begin last_s = s_run; s_run = 0; n_store++; end
        if (recall_active) r_run++;
        else if (r_run > 0) begin last_r = r_run; r_run = 0; n_recall++; end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic pulse(input logic [AW-1:0] a, input logic we, input int low);
        addr = a; we_n = we; ce_n = 1'b0;
        tick(low);
        ce_n = 1'b1; we_n = 1'b1;
        tick(2);
    endtask

    task automatic pattern(input logic [AW-1:0] last, input int low);
        for (int i = 0; i < 5; i++) pulse(seqa[i], 1'b1, low);
        pulse(last, 1'b1, low);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 400 && busy; i++) tick(1);
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        chk(1'b0, "watchdog", 0, 1);
        finish_up();
    end

    int ns, nr;
    initial begin
        tick(4);
        cur_req = "R1";
        chk(busy && out_disable && !store_active && !recall_active, "R1 reset state", busy, 1);
        rst_n = 1'b1;
        tick(3);
        cur_req = "R13";
        pattern(SA, 2);
        tick(3);
        chk(busy && !store_active && !recall_active, "R13 pattern in wait ignored", store_active, 0);
        cur_req = "R1";
        supply_good = 1'b1;
        tick(1);
        chk(recall_active == 1'b1, "R1 power-up recall started", recall_active, 1);
        wait_idle(); tick(2);
        chk(last_r == RC, "R1 power-up recall length", last_r, RC);
        chk(n_store == 0, "R13 no store after wait", n_store, 0);

        cur_req = "R3"; oe_n = 1'b0;
        pattern(SA, 3);
        wait_idle(); tick(2);
        chk(last_s == ST && n_store == 1, "R3 store length", last_s, ST);

        cur_req = "R4"; oe_n = 1'b1;
        pattern(RA, 2);
        wait_idle(); tick(2);
        chk(last_r == RC && n_recall == 2, "R4 recall length", last_r, RC);

        cur_req = "R12";
        pattern(SA, 1);
        tick(1);
        chk(n_store == 1 && (store_active || s_run > 0), "R12 short pulses count", store_active, 1);
        wait_idle(); tick(2);

        cur_req = "R5"; ns = n_store;
        pulse(seqa[0], 1, 2); pulse(seqa[1], 1, 2); pulse(BAD, 1, 2);
        pulse(seqa[3], 1, 2); pulse(seqa[4], 1, 2); pulse(SA, 1, 2);
        tick(3);
        chk(!busy && n_store == ns, "R5 mismatch resets", busy, 0);
        pulse(seqa[0], 1, 2); pulse(seqa[1], 1, 2);
        pattern(SA, 2);
        tick(1);
        chk(store_active, "R5 restart at first address", store_active, 1);
        wait_idle(); tick(2);

        cur_req = "R6"; ns = n_store;
        pulse(seqa[0], 1, 2); pulse(seqa[1], 1, 2); pulse(seqa[2], 1, 2);
        pulse(seqa[3], 0, 2);
        pulse(seqa[3], 1, 2); pulse(seqa[4], 1, 2); pulse(SA, 1, 2);
        tick(3);
        chk(!busy && n_store == ns, "R6 write clears progress", busy, 0);

        cur_req = "R7";
        pattern(SA, 2);
        nr = n_recall;
        pattern(RA, 1);
        wait_idle(); tick(6);
        chk(!busy && n_recall == nr, "R7 pattern during store ignored", n_recall, nr);
        pulse(seqa[4], 1, 1); pulse(RA, 1, 1);
        tick(2);
        chk(!busy, "R7 no leftover progress", busy, 0);

        cur_req = "R8";
        pattern(SA, 2);
        tick(10);
        supply_low = 1'b1; tick(1); supply_low = 1'b0;
        chk(!store_active && !busy, "R8 store aborted", store_active, 0);
        tick(2);
        chk(last_s < ST, "R8 aborted length", last_s, ST);

        cur_req = "R11"; ns = n_store;
        supply_low = 1'b1;
        pattern(SA, 2);
        tick(3);
        chk(!busy && n_store == ns, "R11 store inhibited", busy, 0);
        supply_low = 1'b0;
        pulse(SA, 1, 2);
        tick(2);
        chk(!busy, "R11 progress cleared", busy, 0);

        cur_req = "R9";
        pattern(RA, 2);
        tick(2);
        supply_low = 1'b1; tick(4); supply_low = 1'b0;
        wait_idle(); tick(2);
        chk(last_r == RC, "R9 recall not aborted", last_r, RC);

        cur_req = "R10";
        oe_n = 1'b1; tick(1);
        chk(out_disable, "R10 idle oe high", out_disable, 1);
        oe_n = 1'b0; we_n = 1'b0; ce_n = 1'b0; tick(1);
        chk(!out_disable, "R10 idle enabled", out_disable, 0);
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; tick(2);

        cur_req = "R2";
        oe_n = 1'b0;
        pattern(RA, 4);
        tick(1);
        chk(recall_active, "R2 long pulses with oe low", recall_active, 1);
        wait_idle(); tick(2);

        finish_up();
    end
endmodule